// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM that is 16 bits wide and has an 18-bit word address. The host offers one single-word read or write at a time. The block turns that request into a strobe sequence on the RAM pins. The RAM pins are active-low: chip select, write enable, output enable, and one enable for each byte lane. Every phase of the sequence lasts a whole number of system clocks. Each count comes from a nanosecond limit divided by the clock-period parameter, rounded up, with a floor of one clock.

A read holds chip select and output enable low for the read phase and samples the RAM data on its last clock. The block then pulses a one-clock valid strobe while output enable is high again, which lets the RAM release the bus. A write always starts with a setup phase in which the bus is not yet driven. A write-enable pulse follows, with the write data driven. A hold phase comes last: write enable is high, but chip select, the address and the data stay where they are. The block drives the data bus only during the pulse and hold phases of a write, so it never competes with the RAM for the bus.

Top module: `asram_ctl`

## Requirements
- R1: A read holds ram_cs_n and ram_oe_n low, with ram_we_n high, for N_RD = max(ceil(55/CLK_NS), ceil(25/CLK_NS)) clocks. This is 3 clocks at CLK_NS=20.
- R2: rd_data is sampled from ram_dq_in on the last read clock. rd_valid is high for exactly one clock, on the clock after the read phase. In rd_data, a byte lane whose mask bit is 0 reads as zero.
- R3: host_ready is high only while idle with ram_cs_n high. After the rd_valid clock it returns after ceil(20/CLK_NS) clocks, which is 1 at CLK_NS=20. A read therefore keeps host_ready low for 4 clocks.
- R4: A write runs three phases in order. First, setup: ram_cs_n low, ram_we_n high, bus not driven, for max(ceil(20/CLK_NS),1) clocks. Second, the pulse: ram_we_n low for max(ceil(35/CLK_NS), ceil(25/CLK_NS), ceil(40/CLK_NS) minus setup) clocks. Third, hold: ram_we_n high with ram_cs_n low, for at least 1 clock, and long enough that the whole write lasts ceil(55/CLK_NS) clocks. At CLK_NS=20 the phases last 1, 2 and 1 clocks.
- R5: ram_dq_oe is high only in the write pulse and hold phases, which is 3 clocks at CLK_NS=20. It is never high while ram_oe_n is low. It rises only after a clock with ram_oe_n high.
- R6: req_bmask bit 0 enables the lower lane: ram_lb_n low, data bits 7:0. Bit 1 enables the upper lane: ram_ub_n low, bits 15:8. Both enables hold ~req_bmask for the whole cycle, so only the enabled bytes are written.
- R7: ram_addr changes only while ram_cs_n is high. ram_we_n is low only while ram_cs_n is low.
- R8: A request presented while host_ready is low is ignored.
- R9: During and after reset, every RAM strobe is high, ram_dq_oe and rd_valid are low, and host_ready is high. Reset is asynchronous, so an unfinished write is abandoned at once.
- R10: ram_oe_n and ram_we_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, taken when host_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte-lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| host_ready | output | 1 | Idle and able to take a request |
| rd_valid | output | 1 | One-clock read-data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_ub_n | output | 1 | Upper byte enable, active low |
| ram_lb_n | output | 1 | Lower byte enable, active low |
| ram_dq_out | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the data-bus driver |
| ram_dq_in | input | 16 | Data from the RAM |

## Verification
The bench builds the block with its default parameters, CLK_NS=20 and the 55/25/35/40/20 ns limits. That setting yields unequal phase lengths: 3 read clocks, and a write of 1 setup clock, 2 pulse clocks and 1 hold clock. Because the lengths differ, an off-by-one in any single phase shows up as a wrong strobe count or a wrong strobe position. The bench's RAM model drives a filler pattern on disabled lanes, so the zeroing of masked read lanes can be observed. The full 18-bit address is exercised up to the top word.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RTURN,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD
    } phase_e;

    // Clocks needed to cover a nanosecond limit, never fewer than one.
    function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned period);
        int unsigned n;
        n = (ns + period - 1) / period;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Difference a - b, with a floor of one clock.
    function automatic int unsigned usub1(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    // A phase of len clocks loads len-1 and counts down to zero.
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
    parameter int DW = 16,
    parameter int LW = 8,
    parameter int NL = DW / LW
) (
    input  logic [NL-1:0] be_n,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] masked
);

    // R2: a byte lane that was not enabled returns zero.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign masked[g*LW +: LW] = be_n[g] ? '0 : raw[g*LW +: LW];
    end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int AW        = 18,
    parameter int CLK_NS    = 20,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_OE_NS   = 25,
    parameter int T_REL_NS  = 20,
    parameter int T_AS_NS   = 0,
    parameter int T_WP_NS   = 35,
    parameter int T_DW_NS   = 25,
    parameter int T_CW_NS   = 40,
    parameter int T_AW_NS   = 40,
    parameter int T_WC_NS   = 55
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [1:0]    req_bmask,
    output logic          host_ready,
    output logic          rd_valid,
    output logic [15:0]   rd_data,
    output logic [AW-1:0] ram_addr,
    output logic          ram_cs_n,
    output logic          ram_we_n,
    output logic          ram_oe_n,
    output logic          ram_ub_n,
    output logic          ram_lb_n,
    output logic [15:0]   ram_dq_out,
    output logic          ram_dq_oe,
    input  logic [15:0]   ram_dq_in
);

    localparam int DW = 16;
    localparam int NL = DW / 8;

    // Phase lengths in clocks (R1, R3, R4).
    localparam int unsigned N_RD  = umax(umax(ns_to_clk(T_RC_NS, CLK_NS), ns_to_clk(T_AA_NS, CLK_NS)),
                                         ns_to_clk(T_OE_NS, CLK_NS));
    localparam int unsigned N_REL = ns_to_clk(T_REL_NS, CLK_NS);
    localparam int unsigned N_SET = umax(N_REL, ns_to_clk(T_AS_NS, CLK_NS));
    localparam int unsigned N_WP  = umax(umax(ns_to_clk(T_WP_NS, CLK_NS), ns_to_clk(T_DW_NS, CLK_NS)),
                                         usub1(umax(ns_to_clk(T_CW_NS, CLK_NS), ns_to_clk(T_AW_NS, CLK_NS)), N_SET));
    localparam int unsigned N_WH  = usub1(ns_to_clk(T_WC_NS, CLK_NS), N_SET + N_WP);
    localparam int unsigned N_MAX = umax(umax(N_RD, N_WP), umax(N_WH, N_SET));
    localparam int          CW    = $clog2(N_MAX + 1);

    typedef struct packed {
        phase_e          st;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic [NL-1:0]   be_n;
        logic            cs_n;
        logic            we_n;
        logic            oe_n;
        logic            dq_oe;
        logic            rvalid;
    } regs_t;

    regs_t         r_d, r_q;
    logic          ph_load;
    logic [CW-1:0] ph_len;
    logic          ph_last;
    logic [DW-1:0] rd_masked;

    asram_phase_cnt #(.CW(CW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ph_load),
        .len   (ph_len),
        .last  (ph_last)
    );

    asram_lanes #(.DW(DW), .LW(8), .NL(NL)) u_lanes (
        .be_n   (r_q.be_n),
        .raw    (ram_dq_in),
        .masked (rd_masked)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        ph_load    = 1'b0;
        ph_len     = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                // R8: requests are taken only here.
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.be_n  = ~req_bmask;          // R6
                    r_d.cs_n  = 1'b0;
                    ph_load   = 1'b1;
                    if (req_write) begin
                        r_d.st = ST_WSET;
                        ph_len = CW'(N_SET);
                    end else begin
                        r_d.st   = ST_RD;
                        r_d.oe_n = 1'b0;             // R1
                        ph_len   = CW'(N_RD);
                    end
                end
            end
            ST_RD: begin
                if (ph_last) begin
                    r_d.rdata  = rd_masked;          // R2
                    r_d.rvalid = 1'b1;
                    r_d.cs_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.be_n   = '1;
                    r_d.st     = ST_RTURN;
                    ph_load    = 1'b1;
                    ph_len     = CW'(N_REL);
                end
            end
            ST_RTURN: begin
                if (ph_last) begin
                    r_d.st = ST_IDLE;                // R3
                end
            end
            ST_WSET: begin
                if (ph_last) begin
                    r_d.we_n  = 1'b0;                // R4
                    r_d.dq_oe = 1'b1;                // R5
                    r_d.st    = ST_WPULSE;
                    ph_load   = 1'b1;
                    ph_len    = CW'(N_WP);
                end
            end
            ST_WPULSE: begin
                if (ph_last) begin
                    r_d.we_n = 1'b1;
                    r_d.st   = ST_WHOLD;
                    ph_load  = 1'b1;
                    ph_len   = CW'(N_WH);
                end
            end
            ST_WHOLD: begin
                if (ph_last) begin
                    r_d.cs_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.be_n  = '1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;               // R9
            r_q.addr   <= '0;
            r_q.wdata  <= '0;
            r_q.rdata  <= '0;
            r_q.be_n   <= '1;
            r_q.cs_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.dq_oe  <= 1'b0;
            r_q.rvalid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ready = (r_q.st == ST_IDLE);
    assign rd_valid   = r_q.rvalid;
    assign rd_data    = r_q.rdata;
    assign ram_addr   = r_q.addr;
    assign ram_cs_n   = r_q.cs_n;
    assign ram_we_n   = r_q.we_n;
    assign ram_oe_n   = r_q.oe_n;
    assign ram_lb_n   = r_q.be_n[0];
    assign ram_ub_n   = r_q.be_n[1];
    assign ram_dq_out = r_q.wdata;
    assign ram_dq_oe  = r_q.dq_oe;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [AW-1:0] addr,
    input logic          rd_valid,
    input logic          host_ready
);

    p_oe_we_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    p_drive_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $past(oe_n));

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(addr));

    p_we_under_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n);

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (cs_n && we_n && oe_n && !dq_oe));

endmodule

bind asram_ctl asram_ctl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (ram_cs_n),
    .we_n       (ram_we_n),
    .oe_n       (ram_oe_n),
    .dq_oe      (ram_dq_oe),
    .addr       (ram_addr),
    .rd_valid   (rd_valid),
    .host_ready (host_ready)
);

// File: tb/asram_ctl_tb_top.sv
`timescale 1ns/1ps
module asram_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        host_ready, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n, ram_dq_oe;
    logic [15:0] ram_dq_out, ram_dq_in;

    int total = 0;
    int fails = 0;
    int viol  = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    asram_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_bmask(req_bmask),
        .host_ready(host_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    // Small RAM model: 64 words, indexed by the low address bits.
    logic [15:0] mem [64];
    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    end

    always @(posedge ram_we_n) begin
        if (ram_cs_n === 1'b0 && ram_dq_oe === 1'b1) begin
            if (!ram_lb_n) mem[ram_addr[5:0]][7:0]  = ram_dq_out[7:0];
            if (!ram_ub_n) mem[ram_addr[5:0]][15:8] = ram_dq_out[15:8];
        end
    end

    // Disabled lanes and idle bus carry a filler pattern.
    assign ram_dq_in = (!ram_cs_n && !ram_oe_n && ram_we_n) ?
        { ram_ub_n ? 8'hEE : mem[ram_addr[5:0]][15:8],
          ram_lb_n ? 8'hEE : mem[ram_addr[5:0]][7:0] } : 16'hEEEE;

    // Bus-protocol monitor (R5, R7, R10).
    logic        prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_cs_n = 1'b1;
    logic [17:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_dq_oe && !ram_oe_n) viol++;
            if (ram_dq_oe && !prev_dq_oe && !prev_oe_n) viol++;
            if (!ram_oe_n && !ram_we_n) viol++;
            if (!ram_cs_n && !prev_cs_n && ram_addr != prev_addr) viol++;
        end
        prev_oe_n  <= ram_oe_n;
        prev_dq_oe <= ram_dq_oe;
        prev_cs_n  <= ram_cs_n;
        prev_addr  <= ram_addr;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [15:0] data;
        logic [1:0]  mask;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 18'h00005, 16'hA55A, 2'b11, 16'h0000},
        '{1'b0, 18'h00005, 16'h0000, 2'b11, 16'hA55A},
        '{1'b1, 18'h00005, 16'h1234, 2'b01, 16'h0000},
        '{1'b0, 18'h00005, 16'h0000, 2'b11, 16'hA534},
        '{1'b1, 18'h00005, 16'hBEEF, 2'b10, 16'h0000},
        '{1'b0, 18'h00005, 16'h0000, 2'b11, 16'hBE34},
        '{1'b0, 18'h00005, 16'h0000, 2'b01, 16'h0034},
        '{1'b0, 18'h00005, 16'h0000, 2'b10, 16'hBE00},
        '{1'b1, 18'h3FFFF, 16'hFFFF, 2'b11, 16'h0000},
        '{1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hFFFF},
        '{1'b1, 18'h00000, 16'h0001, 2'b11, 16'h0000},
        '{1'b0, 18'h00000, 16'h0000, 2'b11, 16'h0001}
    };

    // Runs one request; counts strobes at negedges until host_ready returns.
    task automatic run_txn(input logic wr, input logic [17:0] a, input logic [15:0] d,
                           input logic [1:0] m, input bit junk, input logic [15:0] exp);
        int cs_lo = 0, we_lo = 0, oe_lo = 0, drv = 0, vcnt = 0, vpos = 0, busy = 0;
        int be_bad = 0, set_bad = 0;
        logic [15:0] got = '0;
        @(negedge clk); #1;
        while (!host_ready) begin @(negedge clk); #1; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        @(posedge clk); #1;
        if (junk) begin
            req_write = 1'b1; req_addr = 18'h00007; req_wdata = 16'h7777; req_bmask = 2'b11;
        end else begin
            req_valid = 1'b0;
        end
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (host_ready) break;
            busy++;
            if (!ram_cs_n) begin
                cs_lo++;
                if ({ram_ub_n, ram_lb_n} != ~m) be_bad++;
            end
            if (!ram_we_n) we_lo++;
            if (!ram_oe_n) oe_lo++;
            if (ram_dq_oe) drv++;
            if (wr && k == 1 && (ram_cs_n || !ram_we_n || ram_dq_oe)) set_bad++;
            if (rd_valid) begin vcnt++; vpos = k; got = rd_data; end
            if (junk && k == 2) begin #1; req_valid = 1'b0; end
        end
        chk("R6 lane enables", 32'(be_bad), 32'd0);
        chk("R3 busy clocks", 32'(busy), 32'd4);
        if (wr) begin
            chk("R4 write cs low clocks", 32'(cs_lo), 32'd4);
            chk("R4 write pulse clocks", 32'(we_lo), 32'd2);
            chk("R4 setup phase", 32'(set_bad), 32'd0);
            chk("R5 drive clocks", 32'(drv), 32'd3);
            chk("R10 oe during write", 32'(oe_lo), 32'd0);
        end else begin
            chk("R1 read cs low clocks", 32'(cs_lo), 32'd3);
            chk("R1 read oe low clocks", 32'(oe_lo), 32'd3);
            chk("R1 we during read", 32'(we_lo), 32'd0);
            chk("R5 no drive on read", 32'(drv), 32'd0);
            chk("R2 valid count", 32'(vcnt), 32'd1);
            chk("R2 valid position", 32'(vpos), 32'd4);
            chk("R2 read data", 32'(got), 32'(exp));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state, seen while reset is held.
        chk("R9 reset outputs",
            32'({ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n, ram_dq_oe, host_ready, rd_valid}),
            32'b11111010);
        #1 rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_txn(VEC[v].wr, VEC[v].addr, VEC[v].data, VEC[v].mask, 1'b0, VEC[v].exp);
        end

        // R8: a write presented while busy must not reach the RAM.
        run_txn(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b1, 16'hBE34);
        run_txn(1'b0, 18'h00007, 16'h0000, 2'b11, 1'b0, 16'h0000);
        chk("R8 ignored request", 32'(mem[7]), 32'h0);

        // R9: reset during a write pulse abandons it at once.
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00009; req_wdata = 16'h9999;
        req_bmask = 2'b11;
        @(posedge clk); #1 req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 in write pulse", 32'(ram_we_n), 32'd0);
        #1 rst_n = 1'b0;
        #1;
        chk("R9 abandon write",
            32'({ram_cs_n, ram_we_n, ram_oe_n, ram_ub_n, ram_lb_n, ram_dq_oe, host_ready, rd_valid}),
            32'b11111010);
        @(negedge clk); #1 rst_n = 1'b1;

        // Contiguous read after reset still works.
        run_txn(1'b0, 18'h00000, 16'h0000, 2'b11, 1'b0, 16'h0001);

        chk("R5 R7 R10 bus monitor", 32'(viol), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule